// File: doc/BRIEF.md
# ADC Capture Control Register Bank

This block is the software-facing configuration bank of an ADC capture core. A host reaches it through an AXI4-Lite slave port and uses it to read identification words, to release the capture core from its soft reset, to enable the conversion-start pulse generator, and to program the conversion period and the burst length.

Two data registers give indirect access to the converter's own registers. A write to the outgoing data word raises a one-cycle request, carrying the written value, toward the capture logic. The incoming data word holds whatever the capture logic last returned with its valid strobe.

Each AXI access completes with an OKAY response. Address bits [1:0] are ignored, and every register is one 32-bit word.

Top module: `adc_ctl_regbank`

## Requirements
- R1: After a synchronous reset, core_rst_n, trig_en, conv_period, burst_last, dev_wr_req, s_bvalid and s_rvalid are all 0, and the scratch, rate, burst and returned-data words read back as 0.
- R2: Byte 0x400 reads VERSION, 0x404 reads CORE_ID and 0x40C reads 1 when PARALLEL_IF is nonzero and 0 otherwise. Writes to these three addresses change nothing.
- R3: Byte 0x408 is a 32-bit read/write scratch word. Each byte lane i is written only when s_wstrb[i] is 1.
- R4: Byte 0x440 is the control word. Bit 0 drives core_rst_n (reset value 0) and bit 1 drives trig_en. Both bits take the new value when s_wstrb[0] is 1. On read, bits [31:2] are 0.
- R5: Byte 0x444 is a 32-bit conversion-period word written with byte strobes. Its value appears on conv_period.
- R6: Byte 0x448 keeps the low 5 bits of the written data (burst length minus one) when s_wstrb[0] is 1. It drives burst_last, and reads return 0 in bits [31:5].
- R7: A write to byte 0x450 drives dev_wr_req high for exactly one cycle. dev_wr_data equals the written word in that cycle, and s_bvalid is high in that same cycle. Reads of 0x450 return 0.
- R8: Byte 0x44C reads the last dev_rd_data sampled with dev_rd_valid high. AXI writes to it change nothing.
- R9: Reads of unmapped addresses return 0 and writes to them change nothing. s_bresp and s_rresp are always 2'b00.
- R10: AW and W are accepted in either order or in the same cycle. s_bvalid stays high until s_bready is seen. s_rvalid and s_rdata stay unchanged until s_rready is seen.
- R11: When dev_rd_valid and an AXI read of 0x44C are accepted on the same clock edge, the read returns the value held before that edge. The next read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | ADDR_W | Write address (bytes) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| s_araddr | input | ADDR_W | Read address (bytes) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data taken |
| dev_rd_valid | input | 1 | Capture logic returns a device register value |
| dev_rd_data | input | DATA_W | Returned device register value |
| core_rst_n | output | 1 | Active-low soft reset to the capture core |
| trig_en | output | 1 | Conversion-start pulse generator enable |
| conv_period | output | DATA_W | Conversion period in clock cycles |
| burst_last | output | BURST_W | Burst length minus one |
| dev_wr_req | output | 1 | One-cycle device register write request |
| dev_wr_data | output | DATA_W | Data carried by the write request |

## Verification
Two events can fall on the same clock edge: the capture logic returning a device value, and the host reading the returned-data word. The bench raises dev_rd_valid with new data in the same cycle that it presents a read of 0x44C while s_arready is high. It then expects the old word in that response and the new word in a second read. Write strobes, AW/W ordering and back-pressure on both response channels are mixed into a seeded random sequence. Each read is judged against a bench-side model of the registers.

// File: rtl/adc_regbank_pkg.sv
package adc_regbank_pkg;
  // word offsets (byte address / 4); software relies on these
  localparam int unsigned OFF_VERSION = 32'h100;
  localparam int unsigned OFF_IDENT   = 32'h101;
  localparam int unsigned OFF_SCRATCH = 32'h102;
  localparam int unsigned OFF_IFKIND  = 32'h103;
  localparam int unsigned OFF_CTRL    = 32'h110;
  localparam int unsigned OFF_PERIOD  = 32'h111;
  localparam int unsigned OFF_BURST   = 32'h112;
  localparam int unsigned OFF_RDDATA  = 32'h113;
  localparam int unsigned OFF_WRDATA  = 32'h114;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/axil_wr_port.sv
module axil_wr_port #(
  parameter int WORD_W = 10,
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] awword,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NBYTES-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_word,
  output logic [DATA_W-1:0] wr_data,
  output logic [NBYTES-1:0] wr_strb
);
  import adc_regbank_pkg::*;

  logic aw_full, w_full, bvalid_q;
  logic [WORD_W-1:0] aw_q;
  logic [DATA_W-1:0] w_q;
  logic [NBYTES-1:0] s_q;

  assign awready = !aw_full && !bvalid_q;
  assign wready  = !w_full && !bvalid_q;
  assign wr_en   = aw_full && w_full && !bvalid_q;
  assign wr_word = aw_q;
  assign wr_data = w_q;
  assign wr_strb = s_q;
  assign bvalid  = bvalid_q;
  assign bresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_full  <= 1'b0;
      w_full   <= 1'b0;
      bvalid_q <= 1'b0;
      aw_q     <= '0;
      w_q      <= '0;
      s_q      <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_full <= 1'b1;
        aw_q    <= awword;
      end
      if (wvalid && wready) begin
        w_full <= 1'b1;
        w_q    <= wdata;
        s_q    <= wstrb;
      end
      if (wr_en) begin
        aw_full  <= 1'b0;
        w_full   <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/axil_rd_port.sv
module axil_rd_port #(
  parameter int WORD_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] arword,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic [WORD_W-1:0] rd_word,
  input  logic [DATA_W-1:0] rd_data
);
  import adc_regbank_pkg::*;

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign arready = !rvalid_q;
  assign rd_word = arword;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid && arready) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_data;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_reg_core.sv
module adc_reg_core #(
  parameter int          WORD_W      = 10,
  parameter int          DATA_W      = 32,
  parameter int          BURST_W     = 5,
  parameter logic [31:0] VERSION     = 32'h0001_0000,
  parameter logic [31:0] CORE_ID     = 32'h0,
  parameter int          PARALLEL_IF = 1,
  localparam int NBYTES = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_word,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [NBYTES-1:0]  wr_strb,
  input  logic [WORD_W-1:0]  rd_word,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               dev_rd_valid,
  input  logic [DATA_W-1:0]  dev_rd_data,
  output logic               core_rst_n,
  output logic               trig_en,
  output logic [DATA_W-1:0]  conv_period,
  output logic [BURST_W-1:0] burst_last,
  output logic               dev_wr_req,
  output logic [DATA_W-1:0]  dev_wr_data
);
  import adc_regbank_pkg::*;

  localparam logic [WORD_W-1:0] A_VER  = WORD_W'(OFF_VERSION);
  localparam logic [WORD_W-1:0] A_ID   = WORD_W'(OFF_IDENT);
  localparam logic [WORD_W-1:0] A_SCR  = WORD_W'(OFF_SCRATCH);
  localparam logic [WORD_W-1:0] A_IFK  = WORD_W'(OFF_IFKIND);
  localparam logic [WORD_W-1:0] A_CTL  = WORD_W'(OFF_CTRL);
  localparam logic [WORD_W-1:0] A_PER  = WORD_W'(OFF_PERIOD);
  localparam logic [WORD_W-1:0] A_BST  = WORD_W'(OFF_BURST);
  localparam logic [WORD_W-1:0] A_RDD  = WORD_W'(OFF_RDDATA);
  localparam logic [WORD_W-1:0] A_WRD  = WORD_W'(OFF_WRDATA);
  localparam logic [DATA_W-1:0] IFKIND = DATA_W'(PARALLEL_IF != 0);

  logic [DATA_W-1:0]  scratch_w, period_w;
  logic [1:0]         ctl_q;
  logic [BURST_W-1:0] burst_q;
  logic [DATA_W-1:0]  ret_q;
  logic               req_q;
  logic [DATA_W-1:0]  req_data_q;

  // byte-lane writable words
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [7:0] scr_l, per_l;
    always_ff @(posedge clk) begin
      if (rst) begin
        scr_l <= '0;
        per_l <= '0;
      end else if (wr_en && wr_strb[b]) begin
        if (wr_word == A_SCR) scr_l <= wr_data[b*8 +: 8];
        if (wr_word == A_PER) per_l <= wr_data[b*8 +: 8];
      end
    end
    assign scratch_w[b*8 +: 8] = scr_l;
    assign period_w[b*8 +: 8]  = per_l;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      burst_q    <= '0;
      ret_q      <= '0;
      req_q      <= 1'b0;
      req_data_q <= '0;
    end else begin
      if (wr_en && wr_strb[0] && wr_word == A_CTL) ctl_q   <= wr_data[1:0];
      if (wr_en && wr_strb[0] && wr_word == A_BST) burst_q <= wr_data[BURST_W-1:0];
      if (dev_rd_valid) ret_q <= dev_rd_data;
      req_q <= wr_en && (wr_word == A_WRD);
      if (wr_en && wr_word == A_WRD) req_data_q <= wr_data;
    end
  end

  always_comb begin
    case (rd_word)
      A_VER:   rd_data = DATA_W'(VERSION);
      A_ID:    rd_data = DATA_W'(CORE_ID);
      A_SCR:   rd_data = scratch_w;
      A_IFK:   rd_data = IFKIND;
      A_CTL:   rd_data = DATA_W'(ctl_q);
      A_PER:   rd_data = period_w;
      A_BST:   rd_data = DATA_W'(burst_q);
      A_RDD:   rd_data = ret_q;
      default: rd_data = '0;
    endcase
  end

  assign core_rst_n  = ctl_q[0];
  assign trig_en     = ctl_q[1];
  assign conv_period = period_w;
  assign burst_last  = burst_q;
  assign dev_wr_req  = req_q;
  assign dev_wr_data = req_data_q;
endmodule

// File: rtl/adc_ctl_regbank.sv
module adc_ctl_regbank #(
  parameter int          ADDR_W      = 12,
  parameter int          DATA_W      = 32,
  parameter int          BURST_W     = 5,
  parameter logic [31:0] VERSION     = 32'h0001_0000,
  parameter logic [31:0] CORE_ID     = 32'h0,
  parameter int          PARALLEL_IF = 1,
  localparam int NBYTES = DATA_W / 8,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  s_awaddr,
  input  logic               s_awvalid,
  output logic               s_awready,
  input  logic [DATA_W-1:0]  s_wdata,
  input  logic [NBYTES-1:0]  s_wstrb,
  input  logic               s_wvalid,
  output logic               s_wready,
  output logic [1:0]         s_bresp,
  output logic               s_bvalid,
  input  logic               s_bready,
  input  logic [ADDR_W-1:0]  s_araddr,
  input  logic               s_arvalid,
  output logic               s_arready,
  output logic [DATA_W-1:0]  s_rdata,
  output logic [1:0]         s_rresp,
  output logic               s_rvalid,
  input  logic               s_rready,
  input  logic               dev_rd_valid,
  input  logic [DATA_W-1:0]  dev_rd_data,
  output logic               core_rst_n,
  output logic               trig_en,
  output logic [DATA_W-1:0]  conv_period,
  output logic [BURST_W-1:0] burst_last,
  output logic               dev_wr_req,
  output logic [DATA_W-1:0]  dev_wr_data
);
  logic              wr_en;
  logic [WORD_W-1:0] wr_word, rd_word;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [NBYTES-1:0] wr_strb;
  logic              unused_addr_lsbs;

  assign unused_addr_lsbs = ^{s_awaddr[1:0], s_araddr[1:0]};

  axil_wr_port #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_wr (
    .clk(clk), .rst(rst),
    .awword(s_awaddr[ADDR_W-1:2]), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data), .wr_strb(wr_strb)
  );

  axil_rd_port #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst),
    .arword(s_araddr[ADDR_W-1:2]), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .rd_word(rd_word), .rd_data(rd_data)
  );

  adc_reg_core #(
    .WORD_W(WORD_W), .DATA_W(DATA_W), .BURST_W(BURST_W),
    .VERSION(VERSION), .CORE_ID(CORE_ID), .PARALLEL_IF(PARALLEL_IF)
  ) u_core (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_word(wr_word), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_word(rd_word), .rd_data(rd_data),
    .dev_rd_valid(dev_rd_valid), .dev_rd_data(dev_rd_data),
    .core_rst_n(core_rst_n), .trig_en(trig_en), .conv_period(conv_period),
    .burst_last(burst_last), .dev_wr_req(dev_wr_req), .dev_wr_data(dev_wr_data)
  );
endmodule

// File: rtl/adc_ctl_regbank_chk.sv
module adc_ctl_regbank_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic              dev_wr_req,
  input logic              core_rst_n
);
  AST_CORE_HELD_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !core_rst_n); // R1
  AST_WREQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dev_wr_req |=> !dev_wr_req); // R7
  AST_WREQ_WITH_BRESP: assert property (@(posedge clk) disable iff (rst)
    dev_wr_req |-> s_bvalid); // R7
  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    s_bvalid && !s_bready |=> s_bvalid); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata)); // R10
endmodule

bind adc_ctl_regbank adc_ctl_regbank_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .dev_wr_req(dev_wr_req), .core_rst_n(core_rst_n)
);

// File: tb/sim_adc_ctl_regbank.sv
`timescale 1ns/1ps
module sim_adc_ctl_regbank;
  localparam logic [31:0] VER = 32'h0002_0107;
  localparam logic [31:0] CID = 32'h0000_0005;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] s_awaddr = '0;
  logic        s_awvalid = 1'b0;
  logic        s_awready;
  logic [31:0] s_wdata = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_wvalid = 1'b0;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready = 1'b1;
  logic [11:0] s_araddr = '0;
  logic        s_arvalid = 1'b0;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready = 1'b1;
  logic        dev_rd_valid = 1'b0;
  logic [31:0] dev_rd_data = '0;
  logic        core_rst_n, trig_en, dev_wr_req;
  logic [31:0] conv_period, dev_wr_data;
  logic [4:0]  burst_last;

  always #2.5 clk = ~clk;

  adc_ctl_regbank #(.VERSION(VER), .CORE_ID(CID), .PARALLEL_IF(1)) u0 (.*);

  int n_cmp = 0, n_bad = 0, n_req = 0;
  logic [31:0] m_scr = '0, m_rate = '0, m_ret = '0;
  logic [1:0]  m_ctl = '0;
  logic [4:0]  m_bst = '0;

  always @(negedge clk) if (dev_wr_req) n_req++;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] st);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (st[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h400: return VER;
      12'h404: return CID;
      12'h408: return m_scr;
      12'h40C: return 32'd1;
      12'h440: return {30'b0, m_ctl};
      12'h444: return m_rate;
      12'h448: return {27'b0, m_bst};
      12'h44C: return m_ret;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] st);
    if (a == 12'h408) m_scr = merge(m_scr, d, st);
    if (a == 12'h444) m_rate = merge(m_rate, d, st);
    if (a == 12'h440 && st[0]) m_ctl = d[1:0];
    if (a == 12'h448 && st[0]) m_bst = d[4:0];
  endtask

  task automatic send_aw(input logic [11:0] a);
    @(negedge clk); s_awaddr = a; s_awvalid = 1'b1;
    while (!s_awready) @(negedge clk);
    @(negedge clk); s_awvalid = 1'b0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] st);
    @(negedge clk); s_wdata = d; s_wstrb = st; s_wvalid = 1'b1;
    while (!s_wready) @(negedge clk);
    @(negedge clk); s_wvalid = 1'b0;
  endtask

  task automatic axw(input logic [11:0] a, input logic [31:0] d, input logic [3:0] st,
                     input int order);
    case (order)
      1: begin send_aw(a); send_w(d, st); end
      2: begin send_w(d, st); send_aw(a); end
      default: fork send_aw(a); send_w(d, st); join
    endcase
    while (!s_bvalid) @(negedge clk);
    chk("R9 bresp", {30'b0, s_bresp}, 32'h0);
    if (a == 12'h450) begin
      chk("R7 req with bvalid", {31'b0, dev_wr_req}, 32'h1);
      chk("R7 req data", dev_wr_data, d);
    end
    @(negedge clk);
    while (s_bvalid) @(negedge clk);
    if (a == 12'h450) chk("R7 req one cycle", {31'b0, dev_wr_req}, 32'h0);
    model_wr(a, d, st);
  endtask

  task automatic axr(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); s_araddr = a; s_arvalid = 1'b1;
    while (!s_arready) @(negedge clk);
    @(negedge clk); s_arvalid = 1'b0;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
    chk("R9 rresp", {30'b0, s_rresp}, 32'h0);
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a);
    logic [31:0] d;
    axr(a, d);
    chk(req, d, exp_read(a));
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 core_rst_n", {31'b0, core_rst_n}, 0);
    chk("R1 trig_en", {31'b0, trig_en}, 0);
    chk("R1 conv_period", conv_period, 0);
    chk("R1 burst_last", {27'b0, burst_last}, 0);
    chk("R1 dev_wr_req", {31'b0, dev_wr_req}, 0);
    chk("R1 bvalid/rvalid", {30'b0, s_bvalid, s_rvalid}, 0);
    rd_chk("R1 scratch", 12'h408);
    rd_chk("R1 returned", 12'h44C);

    // R2 identification
    rd_chk("R2 version", 12'h400);
    rd_chk("R2 id", 12'h404);
    rd_chk("R2 iftype", 12'h40C);
    axw(12'h400, 32'hFFFF_FFFF, 4'hF, 0);
    axw(12'h40C, 32'h0, 4'hF, 1);
    rd_chk("R2 version after write", 12'h400);
    rd_chk("R2 iftype after write", 12'h40C);

    // R3 scratch byte strobes
    axw(12'h408, 32'h1122_3344, 4'hF, 0);
    axw(12'h408, 32'hAABB_CCDD, 4'b0101, 2);
    axr(12'h408, d);
    chk("R3 strobe merge", d, 32'h11BB_33DD);

    // R4 control
    axw(12'h440, 32'h0000_0003, 4'h1, 0);
    chk("R4 core_rst_n released", {31'b0, core_rst_n}, 1);
    chk("R4 trig_en set", {31'b0, trig_en}, 1);
    axw(12'h440, 32'hFFFF_FFFE, 4'hE, 0);
    chk("R4 no strb0 no change", {30'b0, trig_en, core_rst_n}, 32'h3);
    axw(12'h440, 32'hFFFF_FFFE, 4'hF, 1);
    rd_chk("R4 ctrl readback", 12'h440);
    chk("R4 core_rst_n low", {31'b0, core_rst_n}, 0);

    // R5 period
    axw(12'h444, 32'h0000_1388, 4'hF, 2);
    chk("R5 conv_period", conv_period, 32'h0000_1388);
    rd_chk("R5 period readback", 12'h444);

    // R6 burst
    axw(12'h448, 32'hFFFF_FFFF, 4'hF, 0);
    chk("R6 burst_last", {27'b0, burst_last}, 32'h1F);
    rd_chk("R6 burst readback", 12'h448);

    // R7 write request
    axw(12'h450, 32'hA5A5_1234, 4'hF, 1);
    chk("R7 one pulse", n_req, 1);
    rd_chk("R7 wrdata reads zero", 12'h450);

    // R8 returned data
    @(negedge clk); dev_rd_valid = 1'b1; dev_rd_data = 32'h0BAD_F00D;
    @(negedge clk); dev_rd_valid = 1'b0; dev_rd_data = 32'h1;
    m_ret = 32'h0BAD_F00D;
    rd_chk("R8 returned value", 12'h44C);
    axw(12'h44C, 32'h1234_5678, 4'hF, 0);
    rd_chk("R8 write ignored", 12'h44C);

    // R9 unmapped
    axw(12'h7FC, 32'hDEAD_BEEF, 4'hF, 0);
    rd_chk("R9 unmapped 7FC", 12'h7FC);
    rd_chk("R9 unmapped 000", 12'h000);
    rd_chk("R9 scratch untouched", 12'h408);

    // R10 back-pressure
    s_bready = 1'b0;
    fork
      axw(12'h408, 32'h5555_AAAA, 4'hF, 0);
      begin
        repeat (8) @(negedge clk);
        chk("R10 bvalid held", {31'b0, s_bvalid}, 1);
        s_bready = 1'b1;
      end
    join
    s_rready = 1'b0;
    fork
      axr(12'h408, d);
      begin
        repeat (8) @(negedge clk);
        chk("R10 rvalid held", {31'b0, s_rvalid}, 1);
        chk("R10 rdata held", s_rdata, 32'h5555_AAAA);
        s_rready = 1'b1;
      end
    join
    @(negedge clk);

    // R11 coincident return and read
    @(negedge clk);
    s_araddr = 12'h44C; s_arvalid = 1'b1;
    dev_rd_valid = 1'b1; dev_rd_data = 32'hC0DE_0011;
    @(negedge clk);
    s_arvalid = 1'b0; dev_rd_valid = 1'b0;
    chk("R11 old value returned", s_rdata, 32'h0BAD_F00D);
    @(negedge clk);
    m_ret = 32'hC0DE_0011;
    rd_chk("R11 new value next read", 12'h44C);

    // random mix: R3 R4 R5 R6 R9 R10
    for (int i = 0; i < 60; i++) begin
      logic [11:0] a;
      logic [31:0] dd;
      logic [3:0]  st;
      int sel;
      sel = $urandom_range(0, 6);
      case (sel)
        0: a = 12'h408; 1: a = 12'h444; 2: a = 12'h448; 3: a = 12'h440;
        4: a = 12'h404; 5: a = 12'h500; default: a = 12'h40C;
      endcase
      dd = $urandom();
      st = 4'($urandom_range(0, 15));
      axw(a, dd, st, $urandom_range(0, 2));
      rd_chk("R3/R5/R6/R9 random readback", a);
      chk("R5 random conv_period", conv_period, m_rate);
      chk("R4 random ctrl pins", {30'b0, trig_en, core_rst_n}, {30'b0, m_ctl});
      chk("R6 random burst_last", {27'b0, burst_last}, {27'b0, m_bst});
    end
    chk("R7 no extra pulses", n_req, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule